// File: doc/BRIEF.md
# Audio Interrupt Status Aggregator

This block holds the 32-bit status word of a three-channel audio controller. The two playback channels and the capture channel each send a one-cycle completion pulse when a sample period ends. The block turns these pulses into sticky pending bits, but only for channels whose interrupt enable is on. It also forms a summary bit and drives a level interrupt line. The status word is a plain output for the bus read path.

The interrupt enables sit in the serial control word. The block watches every write to that word and keeps a shadow copy of the three enable bits. Software acknowledges a pending channel by switching its enable from 1 to 0. There is no write-one-to-clear path. The summary bit and the interrupt line come from the same next-state value, so they always change together with the pending bits.

All pins are control or status pins. No data stream passes through the block, so there is no valid/ready interface and no back-pressure to define. Any pulse presented is taken in the same cycle.

Top module: `aud_irq_status`

## Requirements
- R1: Pending bits sit at fixed status positions: bit 0 is the capture channel, bit 1 is the second playback channel, and bit 2 is the first playback channel. In the `chan_done` input, index 0 is the first playback channel, index 1 is the second playback channel and index 2 is the capture channel.
- R2: Status bit 31 equals the OR of the three pending bits in every cycle.
- R3: `irq` is high exactly when at least one pending bit is set, and it changes in the same cycle as the pending bits.
- R4: A pulse on `chan_done[i]` sets that channel's pending bit, visible after the next rising edge, only if the channel's enable was already on before that cycle. The enables are bit 8 (first playback), bit 9 (second playback) and bit 10 (capture) of the serial control word.
- R5: A serial control write that turns a channel's enable from 1 to 0 clears that channel's pending bit after the edge.
- R6: If a completion pulse and an enable-clearing write for the same channel arrive in the same cycle, the bit ends up cleared.
- R7: A write that leaves an enable at 1, a write that leaves it at 0, or a write that changes only bits other than 10:8 does not change any pending bit.
- R8: Status bits 6:5 always read binary 11. Every bit other than 31, 6:5 and 2:0 reads 0.
- R9: After reset the status word is 0x00000060 and `irq` is low. A set pending bit stays set until its enable is cleared or reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_done | input | 3 | One-cycle completion pulses, one per channel |
| sctl_wr | input | 1 | Write strobe for the serial control word |
| sctl_wdata | input | 32 | Serial control write data; only bits 10:8 are used |
| status_word | output | 32 | Status word for bus reads |
| irq | output | 1 | Level interrupt line |

## Verification
The assertions assume each `chan_done` bit and `sctl_wr` are clean synchronous levels that are sampled on the rising edge. They make no assumption about pulse spacing, because back-to-back or simultaneous pulses are legal.

The checker keeps its own copy of the enables, built only from observed writes. Its claims rely on every serial control write passing through `sctl_wr`.

The stimulus changes inputs only at the falling edge. It also places ones in the unused write bits, so an enable decode that looks outside bits 10:8 is caught.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int unsigned CH_N = 3;

  typedef enum logic [1:0] {
    CH_PLAY0 = 2'd0,
    CH_PLAY1 = 2'd1,
    CH_CAPT  = 2'd2
  } chan_e;

  // Channel index i maps to status bit CH_N-1-i.
  function automatic int unsigned pend_pos(input int unsigned ch);
    return CH_N - 1 - ch;
  endfunction
endpackage

// File: rtl/aud_irq_en_shadow.sv
module aud_irq_en_shadow #(
  parameter int unsigned N      = 3,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned EN_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [N-1:0]      en_q,
  output logic [N-1:0]      drop
);
  logic [N-1:0] wr_en_bits;

  assign wr_en_bits = wr_data[EN_LSB +: N];
  // Falling enable: held at 1, written with 0.
  assign drop = wr_en ? (en_q & ~wr_en_bits) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_en_bits;
  end
endmodule

// File: rtl/aud_irq_pend_cell.sv
module aud_irq_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic drop,
  output logic pend_d,
  output logic pend_q
);
  // Clear wins over a simultaneous set.
  assign pend_d = drop ? 1'b0 : (pend_q | hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/aud_irq_status_pack.sv
module aud_irq_status_pack #(
  parameter int unsigned N       = 3,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned SRC_LSB = 5,
  parameter int unsigned SRC_W   = 2
) (
  input  logic [N-1:0]      pend_q,
  input  logic              sum_q,
  output logic [WORD_W-1:0] word
);
  import aud_irq_pkg::*;
  localparam int unsigned SUM_BIT = WORD_W - 1;

  always_comb begin
    word = '0;
    word[SRC_LSB +: SRC_W] = '1;
    word[SUM_BIT] = sum_q;
    for (int unsigned i = 0; i < N; i++) begin
      word[pend_pos(i)] = pend_q[i];
    end
  end
endmodule

// File: rtl/aud_irq_status.sv
module aud_irq_status #(
  parameter int unsigned N      = 3,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned EN_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      chan_done,
  input  logic              sctl_wr,
  input  logic [WORD_W-1:0] sctl_wdata,
  output logic [WORD_W-1:0] status_word,
  output logic              irq
);
  logic [N-1:0] en_q, drop, pend_d, pend_q;
  logic         sum_q;

  aud_irq_en_shadow #(.N(N), .WORD_W(WORD_W), .EN_LSB(EN_LSB)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(sctl_wr), .wr_data(sctl_wdata),
    .en_q(en_q), .drop(drop)
  );

  for (genvar g = 0; g < N; g++) begin : g_ch
    aud_irq_pend_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .hit(chan_done[g] & en_q[g]), .drop(drop[g]),
      .pend_d(pend_d[g]), .pend_q(pend_q[g])
    );
  end

  // Summary register tracks the next pending state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= 1'b0;
    else        sum_q <= |pend_d;
  end

  aud_irq_status_pack #(.N(N), .WORD_W(WORD_W)) u_pack (
    .pend_q(pend_q), .sum_q(sum_q), .word(status_word)
  );

  assign irq = sum_q;
endmodule

// File: rtl/aud_irq_status_chk.sv
module aud_irq_status_chk #(
  parameter int unsigned N      = 3,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned EN_LSB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      chan_done,
  input logic              sctl_wr,
  input logic [WORD_W-1:0] sctl_wdata,
  input logic [WORD_W-1:0] status_word,
  input logic              irq
);
  logic [N-1:0] en_seen;
  logic [N-1:0] pend_view;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_seen <= '0;
    else if (sctl_wr) en_seen <= sctl_wdata[EN_LSB +: N];
  end

  for (genvar i = 0; i < N; i++) begin : g_view
    assign pend_view[i] = status_word[N-1-i];
  end

  a_r3_irq_any: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|status_word[N-1:0]));
  a_r2_summary: assert property (@(posedge clk) disable iff (!rst_n)
    status_word[WORD_W-1] == (|status_word[N-1:0]));
  a_r8_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word[6:5] == 2'b11) && (status_word[WORD_W-2:7] == '0)
    && (status_word[4:N] == '0));

  for (genvar i = 0; i < N; i++) begin : g_ch
    // R5 / R6: falling enable clears, even with a pulse.
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sctl_wr && en_seen[i] && !sctl_wdata[EN_LSB+i]) |=> !pend_view[i]);
    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_done[i] && en_seen[i] && !(sctl_wr && !sctl_wdata[EN_LSB+i]))
      |=> pend_view[i]);
    a_r4_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_view[i] && !(chan_done[i] && en_seen[i])) |=> !pend_view[i]);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_view[i] && !(sctl_wr && en_seen[i] && !sctl_wdata[EN_LSB+i]))
      |=> pend_view[i]);
  end
endmodule

bind aud_irq_status aud_irq_status_chk #(.N(N), .WORD_W(WORD_W), .EN_LSB(EN_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_done(chan_done), .sctl_wr(sctl_wr),
  .sctl_wdata(sctl_wdata), .status_word(status_word), .irq(irq)
);

// File: tb/sim_aud_irq_status.sv
module sim_aud_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  chan_done = '0;
  logic        sctl_wr = 1'b0;
  logic [31:0] sctl_wdata = '0;
  logic [31:0] status_word;
  logic        irq;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  aud_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .chan_done(chan_done), .sctl_wr(sctl_wr),
    .sctl_wdata(sctl_wdata), .status_word(status_word), .irq(irq)
  );

  // {wr, en[2:0] (bit2=capture), pulse[2:0] (idx0=play0), status[2:0] expected}
  localparam logic [9:0] VEC [12] = '{
    {1'b0, 3'b000, 3'b111, 3'b000},  // R4 enables off
    {1'b1, 3'b111, 3'b111, 3'b000},  // R4 enable same cycle does not count
    {1'b0, 3'b000, 3'b001, 3'b100},  // R1 play0 -> bit2
    {1'b0, 3'b000, 3'b100, 3'b101},  // R1 capture -> bit0, R9 sticky
    {1'b1, 3'b111, 3'b000, 3'b101},  // R7 rewrite 1
    {1'b1, 3'b110, 3'b000, 3'b001},  // R5 clear play0
    {1'b0, 3'b000, 3'b011, 3'b011},  // R4 play1 -> bit1, play0 disabled
    {1'b1, 3'b010, 3'b100, 3'b010},  // R6 clear beats pulse
    {1'b1, 3'b000, 3'b000, 3'b000},  // R5 clear play1
    {1'b1, 3'b001, 3'b001, 3'b000},  // R4 late enable
    {1'b0, 3'b000, 3'b001, 3'b100},  // R4 now enabled
    {1'b1, 3'b000, 3'b001, 3'b000}   // R6 clear beats pulse
  };

  function automatic logic [31:0] exp_word(input logic [2:0] st);
    return {(|st), 24'h0, 2'b11, 2'b00, st};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [2:0] en, input logic [2:0] pulse);
    @(negedge clk);
    sctl_wr    = wr;
    sctl_wdata = 32'hA5A5_A0A5 | (32'(en) << 8);
    chan_done  = pulse;
    @(negedge clk);
    sctl_wr   = 1'b0;
    chan_done = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset word", status_word, 32'h0000_0060);
    check("R9 reset irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step(VEC[k][9], VEC[k][8:6], VEC[k][5:3]);
      check($sformatf("R1 R2 R8 vec%0d word", k), status_word, exp_word(VEC[k][2:0]));
      check($sformatf("R3 vec%0d irq", k), {31'b0, irq}, {31'b0, |VEC[k][2:0]});
    end
    // R7: changes outside bits 10:8 leave pending alone
    step(1'b1, 3'b111, 3'b000);
    step(1'b0, 3'b000, 3'b111);
    @(negedge clk);
    sctl_wr = 1'b1; sctl_wdata = 32'hFFFF_F8FF | 32'h0000_0700;
    @(negedge clk);
    sctl_wr = 1'b0;
    check("R7 other bits", status_word, 32'h8000_0067);
    // R9: reset mid-run clears all
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset again", status_word, 32'h0000_0060);
    check("R9 irq low", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    step(1'b0, 3'b000, 3'b111);
    check("R9 enables reset", status_word, 32'h0000_0060);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule